// File: doc/BRIEF.md
# Monotonic Security Level Controller

This block holds a one-byte protection level and rules, for every requested operation, whether it may proceed. The level is kept in a three-state machine whose state encodings are the level codes themselves: `ST_OPEN` (FFh, no protection), `ST_WRLOCK` (FEh, writes locked) and `ST_FULLLOCK` (FCh, reads and writes locked). The level only ever moves toward stronger protection. A level-write request is taken only when its target is stricter than the present level. The full-erase strobe is the single path back to the open state.

The named transitions are:
- T_LOCK_WR: `ST_OPEN` to `ST_WRLOCK`, on a level write with target FEh.
- T_LOCK_ALL_FROM_OPEN: `ST_OPEN` to `ST_FULLLOCK`, on a level write with target FCh.
- T_LOCK_ALL_FROM_WR: `ST_WRLOCK` to `ST_FULLLOCK`, on a level write with target FCh.
- T_ERASE: any state to `ST_OPEN`, on `erase_all`.
- T_HOLD: every other case; the state does not change.

While the synchronous reset is held, the state loads from `load_code`, which stands in for the stored value. An operation request carries a class code. One cycle later the block answers with exactly one of `op_allow` or `op_deny`, judged against the level that held in the request cycle. Whatever executes the operation acts on that answer.

Top module: `sec_guard`

## Requirements
- R1: While `rst_n` is low at a rising edge, the level loads from `load_code`. FFh, FEh and FCh load as themselves, and any other value loads as FCh. During reset `op_allow`, `op_deny` and `lvl_wr_deny` are 0, and `level_code` shows the current level at all times.
- R2: A level write (`lvl_wr_req` high) whose target `lvl_wr_code` is stricter than the current level is accepted, and `level_code` shows the new value one cycle later. The only accepted moves are FFh to FEh, FFh to FCh and FEh to FCh.
- R3: A level write that is not accepted leaves the level unchanged. Such a write may target an equal or looser level, or use a code other than FFh, FEh or FCh. It drives `lvl_wr_deny` high for exactly the one cycle after the request. An accepted write leaves `lvl_wr_deny` low.
- R4: `erase_all` sets the level to FFh one cycle later, from any level. When it coincides with a level write, the erase wins and that write is reported as denied.
- R5: `op_class` uses this encoding: 0 memory write, 1 memory read, 2 configuration write, 3 configuration read, 4 block erase, 5 full erase, 6 blank check, 7 identification read. One cycle after `op_req`, exactly one of `op_allow` and `op_deny` is high, judged by the level in the request cycle. Without a request, both are low.
- R6: At FFh every operation class is allowed.
- R7: At FEh, memory write, configuration write and block erase are denied, and memory read and configuration read are allowed.
- R8: At FCh, memory read and write, configuration read and write, and block erase are all denied.
- R9: Full erase, blank check and identification read are allowed at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the level |
| load_code | input | 8 | Stored level value taken during reset |
| lvl_wr_req | input | 1 | Level-write request strobe |
| lvl_wr_code | input | 8 | Target level code of the write |
| erase_all | input | 1 | Full-erase event; reopens the level |
| op_req | input | 1 | Operation request strobe |
| op_class | input | 3 | Operation class code (R5) |
| op_allow | output | 1 | Operation permitted, one cycle after request |
| op_deny | output | 1 | Operation refused, one cycle after request |
| lvl_wr_deny | output | 1 | One-cycle pulse for a rejected level write |
| level_code | output | 8 | Current level code |

## Verification
A table sweeps every operation class at each of the three levels, plus two out-of-range load values. This exposes any cell of the permission matrix that is wrong, and any fault in mapping undefined codes to the strictest level. Directed level-write sequences cover these cases:
- each accepted move;
- a write to the same level;
- a write to a looser level;
- an undefined target code.

Together they separate a comparison that is too loose from one that is too strict, and a missing deny pulse from one that lasts too long. Two collisions are also tried: an erase arriving together with a write, which shows the erase's priority, and an operation requested together with a lock, which shows that the decision uses the level from before the update.

// File: rtl/sec_pkg.sv
package sec_pkg;

    localparam int CODE_W  = 8;
    localparam int CLASS_W = 3;

    typedef enum logic [CODE_W-1:0] {
        ST_OPEN     = 8'hFF,
        ST_WRLOCK   = 8'hFE,
        ST_FULLLOCK = 8'hFC
    } sec_state_e;

    typedef enum logic [CLASS_W-1:0] {
        OP_MEM_WR   = 3'd0,
        OP_MEM_RD   = 3'd1,
        OP_CFG_WR   = 3'd2,
        OP_CFG_RD   = 3'd3,
        OP_BLK_ERS  = 3'd4,
        OP_FULL_ERS = 3'd5,
        OP_BLANK    = 3'd6,
        OP_ID_RD    = 3'd7
    } op_class_e;

    // Map a raw stored code onto a state; unknown codes go to the strictest level.
    function automatic sec_state_e decode_level(input logic [CODE_W-1:0] code);
        case (code)
            8'hFF:   decode_level = ST_OPEN;
            8'hFE:   decode_level = ST_WRLOCK;
            default: decode_level = ST_FULLLOCK;
        endcase
    endfunction

endpackage

// File: rtl/sec_level_fsm.sv
module sec_level_fsm
    import sec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] load_code,
    input  logic              wr_req,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              erase_all,
    output sec_state_e        state,
    output logic              wr_deny
);

    sec_state_e state_nxt;
    logic       accept;

    always_comb begin
        state_nxt = state;
        accept    = 1'b0;
        if (erase_all) begin
            state_nxt = ST_OPEN;                       // T_ERASE
        end else if (wr_req) begin
            unique case (state)
                ST_OPEN: begin
                    if (wr_code == 8'hFE) begin
                        state_nxt = ST_WRLOCK;         // T_LOCK_WR
                        accept    = 1'b1;
                    end else if (wr_code == 8'hFC) begin
                        state_nxt = ST_FULLLOCK;       // T_LOCK_ALL_FROM_OPEN
                        accept    = 1'b1;
                    end
                end
                ST_WRLOCK: begin
                    if (wr_code == 8'hFC) begin
                        state_nxt = ST_FULLLOCK;       // T_LOCK_ALL_FROM_WR
                        accept    = 1'b1;
                    end
                end
                ST_FULLLOCK: begin
                    accept = 1'b0;                     // T_HOLD
                end
                default: begin
                    state_nxt = ST_FULLLOCK;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= decode_level(load_code);
        else        state <= state_nxt;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) wr_deny <= 1'b0;
        else        wr_deny <= wr_req && !accept;
    end

    // R2
    wr_lock_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !erase_all && state == ST_OPEN && wr_code == 8'hFC) |=> state == ST_FULLLOCK);

    // R3
    deny_holds_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_deny |-> (state == $past(state) || $past(erase_all)));

    // R4
    erase_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> state == ST_OPEN);

    // R2
    never_relax_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase_all && state == ST_FULLLOCK) |=> state == ST_FULLLOCK);

    // R1
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_OPEN, ST_WRLOCK, ST_FULLLOCK});

endmodule

// File: rtl/sec_access_rule.sv
module sec_access_rule
    import sec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  sec_state_e         level,
    input  logic               op_req,
    input  logic [CLASS_W-1:0] op_class,
    output logic               allow,
    output logic               deny
);

    logic permit;

    always_comb begin
        permit = 1'b0;
        unique case (op_class_e'(op_class))
            OP_MEM_WR, OP_CFG_WR, OP_BLK_ERS: permit = (level == ST_OPEN);
            OP_MEM_RD, OP_CFG_RD:             permit = (level != ST_FULLLOCK);
            OP_FULL_ERS, OP_BLANK, OP_ID_RD:  permit = 1'b1;
            default:                          permit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            allow <= 1'b0;
            deny  <= 1'b0;
        end else begin
            allow <= op_req && permit;
            deny  <= op_req && !permit;
        end
    end

    // R5
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |=> (allow ^ deny));

    // R5
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_req |=> !(allow || deny));

    // R9
    always_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_class inside {3'd5, 3'd6, 3'd7}) |=> allow);

    // R8
    full_lock_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && level == ST_FULLLOCK && op_class inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd4}) |=> deny);

endmodule

// File: rtl/sec_guard.sv
module sec_guard
    import sec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  load_code,
    input  logic               lvl_wr_req,
    input  logic [CODE_W-1:0]  lvl_wr_code,
    input  logic               erase_all,
    input  logic               op_req,
    input  logic [CLASS_W-1:0] op_class,
    output logic               op_allow,
    output logic               op_deny,
    output logic               lvl_wr_deny,
    output logic [CODE_W-1:0]  level_code
);

    sec_state_e level;

    sec_level_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_code (load_code),
        .wr_req    (lvl_wr_req),
        .wr_code   (lvl_wr_code),
        .erase_all (erase_all),
        .state     (level),
        .wr_deny   (lvl_wr_deny)
    );

    sec_access_rule u_rule (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .op_req   (op_req),
        .op_class (op_class),
        .allow    (op_allow),
        .deny     (op_deny)
    );

    assign level_code = level;

    // R4
    erase_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_all && lvl_wr_req) |=> (lvl_wr_deny && level_code == 8'hFF));

endmodule

// File: tb/sec_guard_tb.sv
module sec_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] load_code;
    logic       lvl_wr_req;
    logic [7:0] lvl_wr_code;
    logic       erase_all;
    logic       op_req;
    logic [2:0] op_class;
    logic       op_allow, op_deny, lvl_wr_deny;
    logic [7:0] level_code;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    sec_guard u_dut (
        .clk(clk), .rst_n(rst_n), .load_code(load_code),
        .lvl_wr_req(lvl_wr_req), .lvl_wr_code(lvl_wr_code), .erase_all(erase_all),
        .op_req(op_req), .op_class(op_class),
        .op_allow(op_allow), .op_deny(op_deny),
        .lvl_wr_deny(lvl_wr_deny), .level_code(level_code)
    );

    // {load value, op class, expected allow}
    localparam int NV = 26;
    localparam logic [11:0] VEC [0:NV-1] = '{
        {8'hFF,3'd0,1'b1},{8'hFF,3'd1,1'b1},{8'hFF,3'd2,1'b1},{8'hFF,3'd3,1'b1},
        {8'hFF,3'd4,1'b1},{8'hFF,3'd5,1'b1},{8'hFF,3'd6,1'b1},{8'hFF,3'd7,1'b1},
        {8'hFE,3'd0,1'b0},{8'hFE,3'd1,1'b1},{8'hFE,3'd2,1'b0},{8'hFE,3'd3,1'b1},
        {8'hFE,3'd4,1'b0},{8'hFE,3'd5,1'b1},{8'hFE,3'd6,1'b1},{8'hFE,3'd7,1'b1},
        {8'hFC,3'd0,1'b0},{8'hFC,3'd1,1'b0},{8'hFC,3'd2,1'b0},{8'hFC,3'd3,1'b0},
        {8'hFC,3'd4,1'b0},{8'hFC,3'd5,1'b1},{8'hFC,3'd6,1'b1},{8'hFC,3'd7,1'b1},
        {8'h00,3'd1,1'b0},{8'h7E,3'd7,1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] code);
        @(negedge clk);
        rst_n = 1'b0; load_code = code;
        lvl_wr_req = 0; erase_all = 0; op_req = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_op(input logic [2:0] cls, input logic exp, input string req);
        @(negedge clk);
        op_req = 1'b1; op_class = cls;
        @(negedge clk);
        op_req = 1'b0;
        check(req, {op_allow, op_deny}, {exp, ~exp});
    endtask

    task automatic lvl_write(input logic [7:0] code, input logic exp_deny,
                             input logic [7:0] exp_lvl, input string req);
        @(negedge clk);
        lvl_wr_req = 1'b1; lvl_wr_code = code;
        @(negedge clk);
        lvl_wr_req = 1'b0;
        check(req, {lvl_wr_deny, level_code}, {exp_deny, exp_lvl});
    endtask

    initial begin
        rst_n = 0; load_code = 8'hFF; lvl_wr_req = 0; lvl_wr_code = 0;
        erase_all = 0; op_req = 0; op_class = 0;

        // R1: reset state and output quiet
        do_reset(8'hFF);
        check("R1 reset", {op_allow, op_deny, lvl_wr_deny, level_code}, {3'b000, 8'hFF});

        // R6 R7 R8 R9 R1: permission table
        for (int i = 0; i < NV; i++) begin
            do_reset(VEC[i][11:4]);
            run_op(VEC[i][3:1], VEC[i][0], "R6/R7/R8/R9 table");
        end
        do_reset(8'h12);
        check("R1 undefined load", level_code, 8'hFC);

        // R5: no request gives no answer
        @(negedge clk);
        check("R5 idle", {op_allow, op_deny}, 2'b00);

        // R2 R3: level writes
        do_reset(8'hFF);
        lvl_write(8'h55, 1'b1, 8'hFF, "R3 undefined target");
        lvl_write(8'hFF, 1'b1, 8'hFF, "R3 same level");
        lvl_write(8'hFE, 1'b0, 8'hFE, "R2 open to wrlock");
        @(negedge clk);
        check("R3 pulse width", lvl_wr_deny, 1'b0);
        lvl_write(8'hFF, 1'b1, 8'hFE, "R3 loosen");
        @(negedge clk);
        check("R3 pulse ends", lvl_wr_deny, 1'b0);
        lvl_write(8'hFE, 1'b1, 8'hFE, "R3 same wrlock");
        lvl_write(8'hFC, 1'b0, 8'hFC, "R2 wrlock to full");
        lvl_write(8'hFE, 1'b1, 8'hFC, "R3 full to wrlock");

        // R4: erase reopens
        @(negedge clk);
        erase_all = 1'b1;
        @(negedge clk);
        erase_all = 1'b0;
        check("R4 erase", level_code, 8'hFF);
        lvl_write(8'hFC, 1'b0, 8'hFC, "R2 open to full");

        // R4: erase with simultaneous write
        @(negedge clk);
        erase_all = 1'b1; lvl_wr_req = 1'b1; lvl_wr_code = 8'hFC;
        @(negedge clk);
        erase_all = 1'b0; lvl_wr_req = 1'b0;
        check("R4 erase priority", {lvl_wr_deny, level_code}, {1'b1, 8'hFF});

        // R5: decision uses level of request cycle
        @(negedge clk);
        op_req = 1'b1; op_class = 3'd0; lvl_wr_req = 1'b1; lvl_wr_code = 8'hFC;
        @(negedge clk);
        op_req = 1'b0; lvl_wr_req = 1'b0;
        check("R5 pre-update level", {op_allow, op_deny, level_code}, {2'b10, 8'hFC});
        run_op(3'd0, 1'b0, "R8 after lock");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule